// File: doc/BRIEF.md
# GPIO Bank with Masked Half-Word Writes

This block is one bank of a general-purpose I/O controller. It has 26 or 32 pins, set by a parameter. The bank sits behind a simple 32-bit register bus and holds three registers: a data register, a direction register and an output-enable register. Software can write the data register in one access. It can also update one half of the data register through a mask-and-data register, where the upper 16 bits of the written word choose which pins keep their current value.

Each pin is either an output or an input. The pad output carries the pin's data bit only when the pin is an output and its output enable is set. The output enable of every pin leaves the block as a separate signal. An input pin's data bit follows the pad input after a two-flop synchronizer. A read-only alias of the data register lets software read the pin state without the risk of writing it.

All registers reset to zero. A bus access takes one cycle. Read data is registered and appears on the cycle after the read.

Top module: `gpio_bank`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the data, direction and output-enable registers are zero. `pad_out`, `pad_oe` and `bus_rdata` are also zero.
- R2: A write to offset 0x040 replaces the data bit of every output pin with the matching bit of `bus_wdata`. Bits at or above PIN_COUNT are ignored, and a read of 0x040 returns them as zero.
- R3: A read of offset 0x000 or 0x004 returns zero.
- R4: A write to offset 0x000 updates pins 0 to 15. For each pin i, a 1 in bit 16+i keeps the current data bit, and a 0 replaces it with bit i.
- R5: A write to offset 0x004 updates pins 16 and up. Pin 16+k is kept when bit 16+k is 1 and is replaced by bit k when bit 16+k is 0. Only PIN_COUNT-16 pins are involved, which is 10 pins on a 26-pin bank. All other bits of the word are ignored.
- R6: For every pin whose direction bit is 0 (input), the data bit takes the value of `pad_in` after a two-flop synchronizer. Software writes to that data bit have no effect.
- R7: `pad_out[i]` equals data bit i when direction bit i and output-enable bit i are both 1. Otherwise it is 0.
- R8: `pad_oe` presents the output-enable register, one bit per pin. It changes only on a write to offset 0x208.
- R9: A read of offset 0x060 returns the data register. Writes to 0x060 change nothing.
- R10: The direction register (offset 0x204, 1 = output) and the output-enable register (offset 0x208) store bits [PIN_COUNT-1:0] of the write and read back those bits, with the upper bits read as zero.
- R11: `bus_rdata` changes only on the clock edge that completes a read. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | PIN_COUNT | Pad input values |
| pad_out | output | PIN_COUNT | Pad output values |
| pad_oe | output | PIN_COUNT | Per-pin output enable |

## Verification
The hardest case to reach from the ports is a masked write to the upper half on a 26-pin bank. In that case the mask selects only some of the ten pins, and the reserved data and mask bits are set at the same time. Before that write, the stimulus makes every pin an output and sets a known data pattern with one direct write. Any kept bit, replaced bit or leaked reserved bit can then be seen in a read of the data register. Input capture is checked afterwards by turning only the upper pins into inputs and waiting out the synchronizer. The check then confirms that output-pin bits survive and that input-pin bits ignore a later direct write.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;
    localparam int HALF_W = 16;

    localparam logic [ADDR_W-1:0] OFS_MASK_LO = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_DATA_RO = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_OEN     = 12'h208;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_MASK_LO,
        REG_MASK_HI,
        REG_DATA,
        REG_DATA_RO,
        REG_DIR,
        REG_OEN
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_decode.sv
`timescale 1ns/1ps
module gpio_bank_decode
    import gpio_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          kind
);
    always_comb begin
        unique case (addr)
            OFS_MASK_LO: kind = REG_MASK_LO;
            OFS_MASK_HI: kind = REG_MASK_HI;
            OFS_DATA:    kind = REG_DATA;
            OFS_DATA_RO: kind = REG_DATA_RO;
            OFS_DIR:     kind = REG_DIR;
            OFS_OEN:     kind = REG_OEN;
            default:     kind = REG_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
    parameter int WIDTH  = 26,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_data.sv
`timescale 1ns/1ps
module gpio_bank_data
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  reg_sel_e             wr_kind,
    input  logic [BUS_W-1:0]     wdata,
    input  logic [PIN_COUNT-1:0] dir_q,
    input  logic [PIN_COUNT-1:0] sync_in,
    output logic [PIN_COUNT-1:0] data_q
);
    localparam int HI_W = PIN_COUNT - HALF_W;

    logic [PIN_COUNT-1:0] upd_en;
    logic [PIN_COUNT-1:0] upd_val;
    logic [PIN_COUNT-1:0] data_d;

    // Per-bit update enable and value for the three write flavours
    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        if (wr_en) begin
            unique case (wr_kind)
                REG_DATA: begin
                    upd_en  = '1;
                    upd_val = wdata[PIN_COUNT-1:0];
                end
                REG_MASK_LO: begin
                    upd_en[HALF_W-1:0]  = ~wdata[BUS_W-1:HALF_W];
                    upd_val[HALF_W-1:0] = wdata[HALF_W-1:0];
                end
                REG_MASK_HI: begin
                    upd_en[PIN_COUNT-1:HALF_W]  = ~wdata[HALF_W +: HI_W];
                    upd_val[PIN_COUNT-1:HALF_W] = wdata[HI_W-1:0];
                end
                default: begin
                    upd_en  = '0;
                    upd_val = '0;
                end
            endcase
        end
    end

    // Output pins take software updates; input pins follow the synchronizer
    assign data_d = (dir_q & ((upd_en & upd_val) | (~upd_en & data_q)))
                  | (~dir_q & sync_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    reg_sel_e             acc_kind;
    logic                 wr_en;
    logic                 rd_en;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] oen_q;
    logic [PIN_COUNT-1:0] data_q;
    logic [PIN_COUNT-1:0] sync_q;
    logic [BUS_W-1:0]     rd_mux;

    assign wr_en = bus_sel &  bus_we;
    assign rd_en = bus_sel & ~bus_we;

    gpio_bank_decode u_decode (
        .addr (bus_addr),
        .kind (acc_kind)
    );

    gpio_bank_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_q)
    );

    gpio_bank_data #(.PIN_COUNT(PIN_COUNT)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (acc_kind),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .sync_in (sync_q),
        .data_q  (data_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            oen_q <= '0;
        end else if (wr_en) begin
            if (acc_kind == REG_DIR) dir_q <= bus_wdata[PIN_COUNT-1:0];
            if (acc_kind == REG_OEN) oen_q <= bus_wdata[PIN_COUNT-1:0];
        end
    end

    always_comb begin
        unique case (acc_kind)
            REG_DATA, REG_DATA_RO: rd_mux = BUS_W'(data_q);
            REG_DIR:               rd_mux = BUS_W'(dir_q);
            REG_OEN:               rd_mux = BUS_W'(oen_q);
            default:               rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end

    assign pad_out = data_q & dir_q & oen_q;
    assign pad_oe  = oen_q;
endmodule

// File: rtl/gpio_bank_checker.sv
`timescale 1ns/1ps
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int PIN_COUNT = 26
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [11:0]          bus_addr,
    input logic [PIN_COUNT-1:0] wr_bits,
    input logic [31:0]          bus_rdata,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [PIN_COUNT-1:0] dir_q,
    input logic [PIN_COUNT-1:0] data_q,
    input logic [PIN_COUNT-1:0] sync_q
);
    logic rd_mask, wr_ro, wr_oen, wr_dir;
    assign rd_mask = bus_sel && !bus_we && (bus_addr == OFS_MASK_LO || bus_addr == OFS_MASK_HI);
    assign wr_ro   = bus_sel && bus_we && (bus_addr == OFS_DATA_RO);
    assign wr_oen  = bus_sel && bus_we && (bus_addr == OFS_OEN);
    assign wr_dir  = bus_sel && bus_we && (bus_addr == OFS_DIR);

    AST_MASK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_mask |=> (bus_rdata == '0)); // R3
    AST_INPUT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (dir_q == '0) |=> (data_q == $past(sync_q))); // R6
    AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !wr_oen |=> $stable(pad_oe)); // R8
    AST_ALIAS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_ro && (&dir_q)) |=> (data_q == $past(data_q))); // R9
    AST_DIR_STORED: assert property (@(posedge clk) disable iff (!rst_n) wr_dir |=> (dir_q == $past(wr_bits))); // R10
endmodule

bind gpio_bank gpio_bank_checker #(.PIN_COUNT(PIN_COUNT)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_bits   (bus_wdata[PIN_COUNT-1:0]),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .sync_q    (sync_q)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PINS = 26;

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [3:0]  tag;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h204, 32'hFFFF_FFFF, 32'h0,         4'd10}, // R10 all outputs
        '{1'b1, 12'h204, 32'h0,         32'h03FF_FFFF, 4'd10}, // R10 reserved bits zero
        '{1'b0, 12'h040, 32'hFFFF_1234, 32'h0,         4'd2},  // R2
        '{1'b1, 12'h040, 32'h0,         32'h03FF_1234, 4'd2},  // R2
        '{1'b0, 12'h000, 32'hFF00_ABCD, 32'h0,         4'd4},  // R4 keep 15:8
        '{1'b1, 12'h040, 32'h0,         32'h03FF_12CD, 4'd4},  // R4
        '{1'b1, 12'h000, 32'h0,         32'h0,         4'd3},  // R3
        '{1'b0, 12'h004, 32'h0000_0155, 32'h0,         4'd5},  // R5 replace all
        '{1'b1, 12'h040, 32'h0,         32'h0155_12CD, 4'd5},  // R5
        '{1'b0, 12'h004, 32'hFFFF_03FF, 32'h0,         4'd5},  // R5 keep all
        '{1'b1, 12'h040, 32'h0,         32'h0155_12CD, 4'd5},  // R5
        '{1'b0, 12'h004, 32'h03F0_FC0F, 32'h0,         4'd5},  // R5 partial, reserved set
        '{1'b1, 12'h040, 32'h0,         32'h015F_12CD, 4'd5},  // R5
        '{1'b1, 12'h004, 32'h0,         32'h0,         4'd3},  // R3
        '{1'b0, 12'h060, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9 write ignored
        '{1'b1, 12'h060, 32'h0,         32'h015F_12CD, 4'd9},  // R9
        '{1'b1, 12'h040, 32'h0,         32'h015F_12CD, 4'd9},  // R9
        '{1'b0, 12'h208, 32'h0000_FFFF, 32'h0,         4'd8},  // R8
        '{1'b1, 12'h208, 32'h0,         32'h0000_FFFF, 4'd10}, // R10
        '{1'b1, 12'h100, 32'h0,         32'h0,         4'd11}  // R11 unmapped
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [PINS-1:0] pad_in = '0;
    logic [PINS-1:0] pad_out;
    logic [PINS-1:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank #(.PIN_COUNT(PINS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 pad_out", 32'(pad_out), 32'h0);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        rst_n = 1'b1;
        bus_read(12'h040, rd_val); check("R1 data", rd_val, 32'h0);
        bus_read(12'h204, rd_val); check("R1 dir", rd_val, 32'h0);
        bus_read(12'h208, rd_val); check("R1 oen", rd_val, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rd_val);
                check($sformatf("R%0d vec%0d", VECS[i].tag, i), rd_val, VECS[i].exp);
            end else begin
                bus_write(VECS[i].addr, VECS[i].wd);
            end
        end

        // R7 / R8: pad outputs with oen = 0xFFFF, all pins outputs
        check("R7 gated out", 32'(pad_out), 32'h0000_12CD);
        check("R8 oe bits", 32'(pad_oe), 32'h0000_FFFF);
        bus_write(12'h208, 32'h0);
        check("R7 oen off", 32'(pad_out), 32'h0);
        bus_write(12'h208, 32'h0000_FFFF);
        bus_write(12'h204, 32'h0000_00FF);
        check("R7 dir gate", 32'(pad_out), 32'h0000_00CD);

        // R6: input capture on pins 8 and up
        @(negedge clk); pad_in = 26'h123_4567;
        repeat (4) @(negedge clk);
        bus_read(12'h040, rd_val); check("R6 capture", rd_val, 32'h0123_45CD);
        bus_write(12'h040, 32'h0);
        bus_read(12'h040, rd_val); check("R6 input ignores write", rd_val, 32'h0123_4500);
        check("R8 oe unchanged", 32'(pad_oe), 32'h0000_FFFF);
        bus_write(12'h040, 32'h0000_00FF);
        check("R7 only outputs", 32'(pad_out), 32'h0000_00FF);

        // R11: rdata holds across a write
        bus_read(12'h040, rd_val); check("R11 read", rd_val, 32'h0123_45FF);
        bus_write(12'h204, 32'h0);
        check("R11 hold", bus_rdata, 32'h0123_45FF);

        // R1: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 rst pad_oe", 32'(pad_oe), 32'h0);
        check("R1 rst rdata", bus_rdata, 32'h0);
        check("R1 rst pad_out", 32'(pad_out), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule